// File: doc/BRIEF.md
# Chained Prescaler and Period Timer

This block is a 64-bit timer made from two 32-bit counters in series. The first counter divides the timer input clock by a programmable amount and gives a one-cycle tick at the end of each division. The second counter counts those ticks against a programmable period. At the end of each period it raises an interrupt strobe and a DMA event strobe, and it updates an output pin.

The timer input clock is either the system clock itself or the rising edges of an external clock pin. The external pin is synchronized into the system clock domain, so all state runs on a single clock. The output pin has two modes. In pulse mode it carries a pulse 1 to 4 timer clocks wide. In clock mode it toggles, which gives a square wave. Its polarity can be inverted, and a status output mirrors the pin.

Run, clear and enable controls act on the main counter only. The prescaler keeps its phase through a stop or a clear. Dropping enable clears both counters and parks the pin at its inactive level.

Top module: `chain_timer`

## Requirements
- R1: While `enable` is 1, the prescaler counts timer input clocks from 0 up to `pre_period`. On the next input clock after it holds `pre_period`, it clears to 0 and emits one tick. Ticks are therefore `pre_period`+1 input clocks apart.
- R2: The main counter advances by one only on a tick. On the tick that finds it equal to `tmr_period`, it returns to 0. With the internal source, the first interrupt appears at the output P+TP*(P+1)+2 clock cycles after the clock edge that first samples `enable`=1, counted to the sampling point half a cycle after that edge (P=`pre_period`, TP=`tmr_period`). Later interrupts follow every (P+1)*(TP+1) cycles.
- R3: `irq` and `dma_evt` are registered strobes. They are high together, for one cycle per period end.
- R4: When `clk_mode`=0 (pulse mode), each period end drives the uninverted output high for (`pwid`+1) timer clocks, that is (`pwid`+1)*(P+1) system clocks with the internal source. `pwid` is a 2-bit field with values 0 to 3. `tout` lags `irq` by one cycle.
- R5: When `clk_mode`=1 (clock mode), the uninverted output toggles at each period end. It stays high for (P+1)*(TP+1) cycles.
- R6: When `src_sel`=1, the timer input clock is the rising edges of `ext_clk`, taken through a two-flop synchronizer. When `src_sel`=0, every system clock is a timer input clock.
- R7: `tout` is the output level XOR `invert`. `tstat` always equals `tout`.
- R8: While `run`=0, the main counter holds and no interrupt is produced, while the prescaler keeps counting. After `run` returns to 1, interrupts stay aligned to the prescaler tick grid.
- R9: A one-cycle `clr`=1 sets the main counter and the output level to 0 and leaves the prescaler unaffected. The next interrupt comes TP+1 ticks after the clear.
- R10: While `enable`=0, both counters are held at 0, `irq` and `dma_evt` stay 0, and `tout` equals `invert`. Raising `enable` again restarts timing as in R2.
- R11: After a synchronous `rst`, `irq`, `dma_evt`, `tout` and `tstat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External timer clock, asynchronous |
| src_sel | input | 1 | 0: internal clock, 1: external clock edges |
| enable | input | 1 | Block enable; 0 clears both counters |
| run | input | 1 | 1: main counter counts, 0: holds |
| clr | input | 1 | Clears the main counter and the output state |
| pre_period | input | 32 | Prescale period |
| tmr_period | input | 32 | Main timer period |
| pwid | input | 2 | Pulse width minus one, in timer clocks |
| clk_mode | input | 1 | 0: pulse output, 1: toggling output |
| invert | input | 1 | Output polarity inversion |
| irq | output | 1 | Interrupt strobe |
| dma_evt | output | 1 | DMA event strobe |
| tout | output | 1 | Timer output pin |
| tstat | output | 1 | Current output level |

## Verification
The main function is run with several prescale and timer period pairs: the degenerate 0/0 pair, which must fire every cycle, and unequal pairs. Exact interrupt arrival cycles separate the reset-after-match counting from reset-on-match counting. Pulse widths are measured for `pwid` 0, 1 and 3, and the high time is measured in clock mode, which separates pulse stretching from toggling. Stop, clear and external-clock runs are checked against the tick grid and the interval, which shows that the prescaler phase is preserved and that the source select has an effect.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic {OUT_PULSE = 1'b0, OUT_CLOCK = 1'b1} out_mode_e;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/ct_clk_src.sv
module ct_clk_src #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic src_sel,
  output logic step
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ext_clk};
      prev_q <= sync_q[SYNC-1];
      rise_q <= sync_q[SYNC-1] & ~prev_q;
    end
  end

  assign step = (src_sel == ct_pkg::SRC_EXT) ? rise_q : 1'b1;

  // R6
  ext_edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (step) begin
      if (cnt_q == period) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R1
  pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt_q == '0));
  // R10
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0) && !tick);
endmodule

// File: rtl/ct_period.sv
module ct_period #(
  parameter int W    = 32,
  parameter int PW_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            run,
  input  logic            clr,
  input  logic            tick,
  input  logic [W-1:0]    period,
  input  logic [PW_W-1:0] pwid,
  input  logic            mode,
  output logic            fire_q,
  output logic            lvl_q
);
  logic [W-1:0]    cnt_q;
  logic [PW_W-1:0] left_q;
  logic            adv;
  logic            fire;

  assign adv  = tick & run;
  assign fire = adv && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst || !en || clr) begin
      cnt_q  <= '0;
      left_q <= '0;
      fire_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      fire_q <= fire;
      if (adv) cnt_q <= fire ? '0 : cnt_q + 1'b1;
      if (ct_pkg::out_mode_e'(mode) == ct_pkg::OUT_CLOCK) begin
        if (fire) lvl_q <= ~lvl_q;
      end else if (fire) begin
        lvl_q  <= 1'b1;
        left_q <= pwid;
      end else if (adv && lvl_q) begin
        if (left_q == '0) lvl_q <= 1'b0;
        else left_q <= left_q - 1'b1;
      end
    end
  end

  // R2
  wrap_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> (cnt_q == '0));
  // R4
  lvl_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> fire_q);
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !run && !clr) |=> $stable(cnt_q) && !fire_q);
endmodule

// File: rtl/chain_timer.sv
module chain_timer #(
  parameter int W    = 32,
  parameter int PW_W = 2,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_clk,
  input  logic            src_sel,
  input  logic            enable,
  input  logic            run,
  input  logic            clr,
  input  logic [W-1:0]    pre_period,
  input  logic [W-1:0]    tmr_period,
  input  logic [PW_W-1:0] pwid,
  input  logic            clk_mode,
  input  logic            invert,
  output logic            irq,
  output logic            dma_evt,
  output logic            tout,
  output logic            tstat
);
  logic step, tick, fire_q, lvl_q, tout_q;

  ct_clk_src #(.SYNC(SYNC)) u_src (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .src_sel(src_sel), .step(step)
  );

  ct_prescaler #(.W(W)) u_pre (
    .clk(clk), .rst(rst), .en(enable), .step(step),
    .period(pre_period), .tick(tick)
  );

  ct_period #(.W(W), .PW_W(PW_W)) u_per (
    .clk(clk), .rst(rst), .en(enable), .run(run), .clr(clr), .tick(tick),
    .period(tmr_period), .pwid(pwid), .mode(clk_mode),
    .fire_q(fire_q), .lvl_q(lvl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) tout_q <= 1'b0;
    else     tout_q <= enable ? (lvl_q ^ invert) : invert;
  end

  assign irq     = fire_q;
  assign dma_evt = fire_q;
  assign tout    = tout_q;
  assign tstat   = tout_q;

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (tout == $past(invert)) && !irq);
endmodule

// File: tb/chain_timer_bench.sv
module chain_timer_bench;
  logic clk = 1'b0, rst = 1'b1, ext_clk = 1'b0, src_sel = 1'b0;
  logic enable = 1'b0, run = 1'b1, clr = 1'b0, clk_mode = 1'b0, invert = 1'b0;
  logic [31:0] pre_period = '0, tmr_period = '0;
  logic [1:0]  pwid = '0;
  logic irq, dma_evt, tout, tstat;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, hits = 0, last_irq = 0, prev_irq = 0;
  int run_len = 0, last_run = 0, start = 0;
  bit sb_on = 1'b0, ext_run = 1'b0;
  longint exp_q[$];

  chain_timer u_chain_timer (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .src_sel(src_sel),
    .enable(enable), .run(run), .clr(clr), .pre_period(pre_period),
    .tmr_period(tmr_period), .pwid(pwid), .clk_mode(clk_mode),
    .invert(invert), .irq(irq), .dma_evt(dma_evt), .tout(tout), .tstat(tstat)
  );

  always #4 clk = ~clk;

  initial forever begin
    #32;
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected interrupt cycles and tracks output run lengths
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (irq) begin
        hits++;
        prev_irq = last_irq;
        last_irq = cyc;
        chk(dma_evt == irq, "R3 dma_evt with irq", dma_evt, irq);
        if (sb_on) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected irq", cyc, 0);
          else begin
            longint e;
            e = exp_q.pop_front();
            chk(cyc == e, "R2 irq cycle", cyc, e);
          end
        end
      end
      if (tout != invert) run_len++;
      else if (run_len > 0) begin
        last_run = run_len;
        run_len = 0;
      end
    end
  end

  // driver: start the timer and push the expected interrupt cycles
  task automatic start_sb(input int p, input int tp, input int n);
    int g;
    pre_period = p;
    tmr_period = tp;
    @(negedge clk); #1;
    start = cyc;
    enable = 1'b1;
    for (int m = 0; m < n; m++)
      exp_q.push_back(start + p + tp * (p + 1) + 2 + m * (p + 1) * (tp + 1));
    sb_on = 1'b1;
    g = 0;
    while (exp_q.size() > 0 && g < 2000) begin
      @(negedge clk); #2;
      g++;
    end
    sb_on = 1'b0;
    chk(exp_q.size() == 0, "R2 all irqs seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic go_idle();
    @(negedge clk); #1;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic wait_hits(input int target, input int guard);
    int g;
    g = 0;
    while (hits < target && g < guard) begin
      @(negedge clk); #2;
      g++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int h, cc;
    repeat (3) @(negedge clk);
    chk(irq == 0 && dma_evt == 0, "R11 strobes after reset", irq, 0);
    chk(tout == 0 && tstat == 0, "R11 output after reset", tout, 0);
    #1 rst = 1'b0;

    // R10: disabled block stays quiet
    repeat (6) @(negedge clk);
    chk(hits == 0 && tout == 0, "R10 idle quiet", hits, 0);

    // R1 R2 R4: P=2 TP=3 pulse width 1
    pwid = 2'd0;
    start_sb(2, 3, 3);
    repeat (6) @(negedge clk);
    chk(last_run == 3, "R4 pwid=0 width", last_run, 3);
    go_idle();

    // R2 boundary: both periods zero fire every cycle
    start_sb(0, 0, 5);
    go_idle();

    // R4: pwid=3 with P=4 TP=4
    pwid = 2'd3;
    start_sb(4, 4, 2);
    repeat (22) @(negedge clk);
    chk(last_run == 20, "R4 pwid=3 width", last_run, 20);
    go_idle();

    // R5: clock mode P=1 TP=2
    clk_mode = 1'b1;
    start_sb(1, 2, 3);
    repeat (2) @(negedge clk);
    chk(last_run == 6, "R5 toggle high time", last_run, 6);
    chk(tstat == tout, "R7 tstat mirrors tout", tstat, tout);
    go_idle();
    clk_mode = 1'b0;

    // R7 R10: inversion idle level and inverted pulse
    invert = 1'b1;
    repeat (3) @(negedge clk);
    chk(tout == 1 && tstat == 1, "R7 inverted idle level", tout, 1);
    pwid = 2'd1;
    start_sb(1, 3, 2);
    repeat (8) @(negedge clk);
    chk(last_run == 4, "R7 inverted pulse width", last_run, 4);
    go_idle();
    invert = 1'b0;
    repeat (2) @(negedge clk);

    // R8: stop and resume, P=3 TP=2
    pwid = 2'd0;
    start_sb(3, 2, 1);
    @(negedge clk); #1 run = 1'b0;
    repeat (2) @(negedge clk);
    h = hits;
    repeat (30) @(negedge clk);
    chk(hits == h, "R8 no irq while stopped", hits, h);
    #1 run = 1'b1;
    wait_hits(h + 1, 20);
    chk(hits > h, "R8 irq after resume", hits, h + 1);
    chk((last_irq - start - 1) % 4 == 0, "R8 prescaler phase kept", (last_irq - start - 1) % 4, 0);

    // R9: clear six cycles after an interrupt
    h = hits;
    wait_hits(h + 1, 20);
    repeat (5) @(negedge clk);
    #1 cc = cyc;
    h = hits;
    clr = 1'b1;
    @(negedge clk); #1 clr = 1'b0;
    wait_hits(h + 1, 40);
    chk(last_irq >= cc + 10 && last_irq <= cc + 13, "R9 irq after clear", last_irq - cc, 10);
    chk((last_irq - start - 1) % 4 == 0, "R9 prescaler phase kept", (last_irq - start - 1) % 4, 0);
    go_idle();

    // R6: external clock every 8 cycles, P=1 TP=1 gives 32-cycle interval
    src_sel = 1'b1;
    ext_run = 1'b1;
    pre_period = 1;
    tmr_period = 1;
    @(negedge clk); #1 enable = 1'b1;
    h = hits;
    wait_hits(h + 3, 300);
    chk(last_irq - prev_irq == 32, "R6 external interval", last_irq - prev_irq, 32);

    // R10: disable mid-run, then restart from zero
    @(negedge clk); #1 enable = 1'b0;
    repeat (3) @(negedge clk);
    h = hits;
    repeat (40) @(negedge clk);
    chk(hits == h && tout == invert, "R10 disabled mid-run", hits, h);
    ext_run = 1'b0;
    src_sel = 1'b0;
    start_sb(2, 1, 2);
    go_idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule